// File: doc/BRIEF.md
# Raster Display Timing Generator

This block produces the sync, blanking and data-enable timing for a parallel RGB panel. Software sets the active size and every porch and sync width through a small write-only register port. All of these fields hold the wanted count minus one. A pixel-clock enable input paces a horizontal pixel counter and a vertical line counter. The block decodes hsync, vsync and data-enable from those counters and also drives the counters out, so a pixel fetch stage can follow the raster.

Each line runs active, front porch, sync, then back porch. Each frame runs through the same four segments in lines. Starting the block takes effect at once. Stopping it is held back until the next vsync leading edge, so a frame is never cut off in the middle. A frame interrupt can be tied to either edge of vsync. It latches into a pending flag that software clears by writing one to it. A separate line-match event pulses when the line counter reaches a programmed line.

Top module: `rgb_raster_timing`

Register addresses (`cfg_addr`), all fields written from `cfg_wdata`:
0 control (bit0 run, bit1 hsync active-high, bit2 vsync active-high); 1 active width-1; 2 horizontal front porch-1; 3 hsync width-1; 4 horizontal back porch-1; 5 active height-1; 6 vertical front porch-1; 7 vsync width-1; 8 vertical back porch-1; 9 match line; 10 interrupt control (bit0 global enable, bit1 frame enable, bit2 edge select: 0 leading, 1 trailing); 11 status (bit0 frame pending, bit1 line-match pending; write one to clear).

## Requirements
- R1: While reset is low and after it, both syncs sit at their inactive level (high with the default active-low polarity), de_o is 0, pix_x_o and pix_y_o are 0, status_o is 0 and frame_irq_o is 0.
- R2: pix_x_o counts from 0 to HA+HF+HS+HB+3 and wraps, where HA, HF, HS, HB are the values at addresses 1 to 4. hsync is active for x from HA+HF+2 up to HA+HF+HS+2.
- R3: pix_y_o advances by one each time pix_x_o wraps. It wraps after VA+VF+VS+VB+3, using addresses 5 to 8. vsync is active for lines VA+VF+2 up to VA+VF+VS+2.
- R4: de_o is 1 exactly when the block runs and pix_x_o is at most HA and pix_y_o is at most VA.
- R5: Control bit1 (bit2) set makes hsync (vsync) active-high; cleared, the sync is active-low. A stopped block holds both syncs inactive.
- R6: While pix_en is low, the counters and all timing outputs hold their values.
- R7: Writing control bit0 = 1 to a stopped block starts counting from (0,0) on the next enabled cycle. Writing bit0 = 0 to a running block takes effect at the next vsync leading edge, where both counters return to 0 and stay there.
- R8: line_hit_o pulses for one enabled cycle when pix_x_o is 0 and pix_y_o equals the match line at address 9. It sets status bit1 on the following edge.
- R9: Status bit0 is set at the vsync edge chosen by interrupt control bit2. It is set only when interrupt control bits 0 and 1 are both 1.
- R10: A write to the status address clears exactly the bits written as one. Other pending bits stay set.
- R11: frame_irq_o follows status bit0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; counters step when high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | FW (12) | Register write data |
| hsync_o | output | 1 | Horizontal sync, programmable polarity |
| vsync_o | output | 1 | Vertical sync, programmable polarity |
| de_o | output | 1 | Data enable, high in the active area |
| pix_x_o | output | FW+2 (14) | Current pixel within the line |
| pix_y_o | output | FW+2 (14) | Current line within the frame |
| line_hit_o | output | 1 | One-cycle line-match pulse |
| frame_irq_o | output | 1 | Frame interrupt request |
| status_o | output | 2 | Pending flags: bit0 frame, bit1 line match |

## Verification
The assertions assume that the timing fields change only while the block is stopped or between frames, so a counter never sits beyond a shortened segment. They also assume that a status clear never lands in the same cycle as a new event for the same bit. The stimulus writes timing fields only before the first start. Every status write is made with pix_en held low, so no event can coincide with it. The reference model follows the same ordering: an event that sets a flag wins over a clear in the same cycle.

// File: rtl/rrt_pkg.sv
`timescale 1ns/1ps
// Shared constants for the raster timing generator: register addresses,
// timing-field indices and the segment encoding used by both counters.
// Assumes a 4-bit register address space.
package rrt_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL       = 4'd0;
    localparam logic [ADDR_W-1:0] A_TIMING     = 4'd1;  // first of eight timing fields
    localparam logic [ADDR_W-1:0] A_LINE_MATCH = 4'd9;
    localparam logic [ADDR_W-1:0] A_IRQ_CTRL   = 4'd10;
    localparam logic [ADDR_W-1:0] A_STATUS     = 4'd11;

    localparam int N_TIMING = 8;
    localparam int F_H_ACT   = 0;
    localparam int F_H_FRONT = 1;
    localparam int F_H_SYNC  = 2;
    localparam int F_H_BACK  = 3;
    localparam int F_V_ACT   = 4;
    localparam int F_V_FRONT = 5;
    localparam int F_V_SYNC  = 6;
    localparam int F_V_BACK  = 7;

    // Order of the segments inside one line or one frame.
    typedef enum logic [1:0] {
        SEG_ACTIVE = 2'd0,
        SEG_FRONT  = 2'd1,
        SEG_SYNC   = 2'd2,
        SEG_BACK   = 2'd3
    } seg_e;
endpackage

// File: rtl/rrt_axis.sv
`timescale 1ns/1ps
// One raster axis counter (pixels in a line, or lines in a frame).
// Counts 0..total-1 where total is the sum of four minus-one fields, and
// decodes the current segment in the order active, front, sync, back.
// Assumes fields change only while the counter is cleared or at a wrap;
// a counter found past the end wraps on its next step.
module rrt_axis
    import rrt_pkg::*;
#(
    parameter int FW = 12,
    localparam int CW = FW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [FW-1:0] act_m1,
    input  logic [FW-1:0] front_m1,
    input  logic [FW-1:0] sync_m1,
    input  logic [FW-1:0] back_m1,
    output logic [CW-1:0] cnt,
    output logic          at_last,
    output seg_e          seg,
    output logic          pre_sync,
    output logic          pre_back
);
    logic [CW-1:0] front_start;
    logic [CW-1:0] sync_start;
    logic [CW-1:0] back_start;
    logic [CW-1:0] last_pos;

    // Segment boundaries from the minus-one fields.
    always_comb begin
        front_start = CW'(act_m1) + CW'(1);
        sync_start  = front_start + CW'(front_m1) + CW'(1);
        back_start  = sync_start + CW'(sync_m1) + CW'(1);
        last_pos    = back_start + CW'(back_m1);
    end

    assign at_last  = (cnt >= last_pos);
    assign pre_sync = (cnt == sync_start - CW'(1));
    assign pre_back = (cnt == back_start - CW'(1));

    // Segment decode of the present count.
    always_comb begin
        if (cnt < front_start)      seg = SEG_ACTIVE;
        else if (cnt < sync_start)  seg = SEG_FRONT;
        else if (cnt < back_start)  seg = SEG_SYNC;
        else                        seg = SEG_BACK;
    end

    // Position counter: clear, step with wrap, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (step)   cnt <= at_last ? '0 : cnt + CW'(1);
    end
endmodule

// File: rtl/rrt_regs.sv
`timescale 1ns/1ps
// Register file, run control and pending flags of the timing generator.
// Holds the eight timing fields and the match line, applies a start at once
// and a stop only at the vsync leading edge, and keeps the write-one-to-clear
// status. Assumes event inputs are single-cycle strobes.
module rrt_regs
    import rrt_pkg::*;
#(
    parameter int FW = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [FW-1:0]                wdata,
    input  logic                         ev_lead,
    input  logic                         ev_trail,
    input  logic                         ev_hit,
    output logic [N_TIMING-1:0][FW-1:0]  tfield,
    output logic [FW-1:0]                line_match,
    output logic                         run_act,
    output logic                         run_req,
    output logic                         hs_hi,
    output logic                         vs_hi,
    output logic                         irq,
    output logic [1:0]                   status
);
    logic irq_glb, irq_frm, irq_trail;
    logic pend_f, pend_l;
    logic wr_ctrl, wr_stat, wr_irq, wr_match;
    logic run_req_nxt, frame_set;
    logic [N_TIMING-1:0] wr_field;

    assign wr_ctrl  = we && (addr == A_CTRL);
    assign wr_stat  = we && (addr == A_STATUS);
    assign wr_irq   = we && (addr == A_IRQ_CTRL);
    assign wr_match = we && (addr == A_LINE_MATCH);

    // Per-field write strobes, one decoder per timing register.
    generate
        for (genvar i = 0; i < N_TIMING; i++) begin : g_field_sel
            assign wr_field[i] = we && (addr == A_TIMING + ADDR_W'(i));
        end
    endgenerate

    // Timing field storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tfield <= '0;
        end else begin
            for (int i = 0; i < N_TIMING; i++)
                if (wr_field[i]) tfield[i] <= wdata;
        end
    end

    // Match line and interrupt configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_match <= '0;
            irq_glb    <= 1'b0;
            irq_frm    <= 1'b0;
            irq_trail  <= 1'b0;
        end else begin
            if (wr_match) line_match <= wdata;
            if (wr_irq) begin
                irq_glb   <= wdata[0];
                irq_frm   <= wdata[1];
                irq_trail <= wdata[2];
            end
        end
    end

    // Requested run state and sync polarities, live on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_req <= 1'b0;
            hs_hi   <= 1'b0;
            vs_hi   <= 1'b0;
        end else if (wr_ctrl) begin
            run_req <= wdata[0];
            hs_hi   <= wdata[1];
            vs_hi   <= wdata[2];
        end
    end

    assign run_req_nxt = wr_ctrl ? wdata[0] : run_req;

    // Applied run state: start at once, stop only at the vsync leading edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_act <= 1'b0;
        else if (!run_act)  run_act <= run_req_nxt;
        else if (ev_lead)   run_act <= run_req;
    end

    assign frame_set = irq_glb && irq_frm && (irq_trail ? ev_trail : ev_lead);

    // Pending flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_f <= 1'b0;
            pend_l <= 1'b0;
        end else begin
            pend_f <= frame_set | (pend_f & ~(wr_stat & wdata[0]));
            pend_l <= ev_hit    | (pend_l & ~(wr_stat & wdata[1]));
        end
    end

    assign status = {pend_l, pend_f};
    assign irq    = pend_f;

    // R9: the frame flag only rises when both enables were set.
    p_frame_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_f) |-> $past(irq_glb && irq_frm));

    // R10: a clear aimed at the other bit leaves the frame flag set.
    p_w1c_other_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !wdata[0] && pend_f) |=> pend_f);

    // R7: a running block only stops at a vsync leading edge.
    p_stop_at_vsync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_act && !ev_lead) |=> run_act);
endmodule

// File: rtl/rgb_raster_timing.sv
`timescale 1ns/1ps
// Top of the raster timing generator for a parallel RGB panel.
// Ties the register file to a horizontal and a vertical axis counter,
// forms the vsync-edge and line-match events, and decodes the sync and
// data-enable outputs. Assumes pix_en is synchronous to clk.
module rgb_raster_timing
    import rrt_pkg::*;
#(
    parameter int FW = 12,
    localparam int CW = FW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [FW-1:0]     cfg_wdata,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [CW-1:0]     pix_x_o,
    output logic [CW-1:0]     pix_y_o,
    output logic              line_hit_o,
    output logic              frame_irq_o,
    output logic [1:0]        status_o
);
    logic [N_TIMING-1:0][FW-1:0] tfield;
    logic [FW-1:0] line_match;
    logic run_act, run_req, hs_hi, vs_hi;
    logic h_step, h_wrap, clr_cnt;
    logic ev_lead, ev_trail, ev_hit;
    logic h_last, v_last;
    logic h_pre_sync, h_pre_back, v_pre_sync, v_pre_back;
    seg_e h_seg, v_seg;

    rrt_regs #(.FW(FW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .ev_lead    (ev_lead),
        .ev_trail   (ev_trail),
        .ev_hit     (ev_hit),
        .tfield     (tfield),
        .line_match (line_match),
        .run_act    (run_act),
        .run_req    (run_req),
        .hs_hi      (hs_hi),
        .vs_hi      (vs_hi),
        .irq        (frame_irq_o),
        .status     (status_o)
    );

    // Stepping and clearing of both counters.
    assign h_step  = run_act && pix_en;
    assign h_wrap  = h_step && h_last;
    assign ev_lead = h_wrap && v_pre_sync;
    assign ev_trail = h_wrap && v_pre_back;
    assign clr_cnt = !run_act || (ev_lead && !run_req);

    rrt_axis #(.FW(FW)) u_hcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_cnt),
        .step     (h_step),
        .act_m1   (tfield[F_H_ACT]),
        .front_m1 (tfield[F_H_FRONT]),
        .sync_m1  (tfield[F_H_SYNC]),
        .back_m1  (tfield[F_H_BACK]),
        .cnt      (pix_x_o),
        .at_last  (h_last),
        .seg      (h_seg),
        .pre_sync (h_pre_sync),
        .pre_back (h_pre_back)
    );

    rrt_axis #(.FW(FW)) u_vcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_cnt),
        .step     (h_wrap),
        .act_m1   (tfield[F_V_ACT]),
        .front_m1 (tfield[F_V_FRONT]),
        .sync_m1  (tfield[F_V_SYNC]),
        .back_m1  (tfield[F_V_BACK]),
        .cnt      (pix_y_o),
        .at_last  (v_last),
        .seg      (v_seg),
        .pre_sync (v_pre_sync),
        .pre_back (v_pre_back)
    );

    // Line-match strobe on the first pixel of the chosen line.
    assign ev_hit     = h_step && (pix_x_o == '0) && (pix_y_o == CW'(line_match));
    assign line_hit_o = ev_hit;

    // Output decode with programmable sync polarity.
    assign hsync_o = (run_act && h_seg == SEG_SYNC) ? hs_hi : ~hs_hi;
    assign vsync_o = (run_act && v_seg == SEG_SYNC) ? vs_hi : ~vs_hi;
    assign de_o    = run_act && (h_seg == SEG_ACTIVE) && (v_seg == SEG_ACTIVE);

    // R6: counters hold while the pixel enable is low.
    p_hold_on_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_act && !pix_en) |=> ($stable(pix_x_o) && $stable(pix_y_o)));

    // R7: a stopped block keeps both counters at home.
    p_stopped_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_act |-> (pix_x_o == '0 && pix_y_o == '0));

    // R8: every line-match strobe leaves its pending flag set.
    p_line_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_hit_o |=> status_o[1]);

    // R3: the end of the last line returns the line counter to zero.
    p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wrap && v_last && !clr_cnt) |=> (pix_y_o == '0));

    // R2: stepping off the pre-sync pixel enters the sync segment.
    p_hsync_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_step && !clr_cnt && h_pre_sync && !h_last) |=> (h_seg == SEG_SYNC));

    // R2: stepping off the last sync pixel enters the back porch.
    p_hback_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_step && !clr_cnt && h_pre_back && !h_last) |=> (h_seg == SEG_BACK));
endmodule

// File: tb/rgb_raster_timing_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task advances a requirement-level model and
// pushes the expected outputs; a monitor pops and compares at the falling edge.
module rgb_raster_timing_tb_top;
    import rrt_pkg::*;
    localparam int FW = 12;
    localparam int CW = FW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_en = 1'b0;
    logic cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [FW-1:0] cfg_wdata = '0;
    logic hsync_o, vsync_o, de_o, line_hit_o, frame_irq_o;
    logic [CW-1:0] pix_x_o, pix_y_o;
    logic [1:0] status_o;

    always #10 clk = ~clk;

    rgb_raster_timing #(.FW(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .de_o(de_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o),
        .line_hit_o(line_hit_o), .frame_irq_o(frame_irq_o), .status_o(status_o)
    );

    typedef struct {
        int x; int y; bit hs; bit vs; bit de; bit hit; bit irq; bit [1:0] st;
    } exp_t;
    exp_t sb_q[$];

    int n_chk = 0;
    int n_fail = 0;

    // Model state, built from the requirements.
    int mx = 0, my = 0, mmatch = 0;
    int mf[8] = '{default: 0};
    bit mrun = 0, mreq = 0, mhh = 0, mvh = 0, mig = 0, mife = 0, mitr = 0;
    bit mpf = 0, mpl = 0;
    bit p_pe = 0, p_we = 0;
    int p_a = 0, p_d = 0;

    task automatic chk(input string tag, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // One clock edge of the model with the inputs present at that edge.
    task automatic m_adv(input bit pe, input bit we, input int a, input int d);
        int hss, hbs, hl, vss, vbs, vl;
        bit stp, hw, ld, tr, ht, fset, old_run, old_req;
        hss = mf[F_H_ACT] + mf[F_H_FRONT] + 2;
        hbs = hss + mf[F_H_SYNC] + 1;
        hl  = hbs + mf[F_H_BACK];
        vss = mf[F_V_ACT] + mf[F_V_FRONT] + 2;
        vbs = vss + mf[F_V_SYNC] + 1;
        vl  = vbs + mf[F_V_BACK];
        stp = mrun && pe;
        hw  = stp && (mx >= hl);
        ld  = hw && (my == vss - 1);
        tr  = hw && (my == vbs - 1);
        ht  = stp && (mx == 0) && (my == mmatch);
        fset = mig && mife && (mitr ? tr : ld);
        if (we && a == int'(A_STATUS) && d[0]) mpf = 0;
        if (we && a == int'(A_STATUS) && d[1]) mpl = 0;
        if (fset) mpf = 1;
        if (ht) mpl = 1;
        old_run = mrun;
        old_req = mreq;
        if (!old_run || (ld && !old_req)) begin
            mx = 0; my = 0;
        end else if (stp) begin
            if (hw) begin
                mx = 0;
                my = (my >= vl) ? 0 : my + 1;
            end else begin
                mx = mx + 1;
            end
        end
        if (!old_run) mrun = (we && a == int'(A_CTRL)) ? d[0] : old_req;
        else if (ld) mrun = old_req;
        if (we) begin
            if (a == int'(A_CTRL)) begin
                mreq = d[0]; mhh = d[1]; mvh = d[2];
            end else if (a >= 1 && a <= 8) begin
                mf[a-1] = d;
            end else if (a == int'(A_LINE_MATCH)) begin
                mmatch = d;
            end else if (a == int'(A_IRQ_CTRL)) begin
                mig = d[0]; mife = d[1]; mitr = d[2];
            end
        end
    endtask

    task automatic push_exp(input bit pe);
        exp_t e;
        int hss, hbs, vss, vbs;
        bit hin, vin;
        hss = mf[F_H_ACT] + mf[F_H_FRONT] + 2;
        hbs = hss + mf[F_H_SYNC] + 1;
        vss = mf[F_V_ACT] + mf[F_V_FRONT] + 2;
        vbs = vss + mf[F_V_SYNC] + 1;
        hin = mrun && mx >= hss && mx < hbs;
        vin = mrun && my >= vss && my < vbs;
        e.x = mx; e.y = my;
        e.hs = hin ? mhh : !mhh;
        e.vs = vin ? mvh : !mvh;
        e.de = mrun && mx <= mf[F_H_ACT] && my <= mf[F_V_ACT];
        e.hit = mrun && pe && mx == 0 && my == mmatch;
        e.st = {mpl, mpf};
        e.irq = mpf;
        sb_q.push_back(e);
    endtask

    // Driver: one cycle of stimulus, model update and expected push.
    task automatic step(input bit pe, input bit we = 1'b0, input int a = 0, input int d = 0);
        @(posedge clk);
        #2;
        m_adv(p_pe, p_we, p_a, p_d);
        pix_en = pe; cfg_we = we; cfg_addr = ADDR_W'(a); cfg_wdata = FW'(d);
        p_pe = pe; p_we = we; p_a = a; p_d = d;
        push_exp(pe);
    endtask

    task automatic run(input int n, input bit pe);
        for (int i = 0; i < n; i++) step(pe);
    endtask

    // Monitor: compare design outputs with the oldest expected item.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb_q.pop_front();
            bad = 0;
            n_chk++;
            if (int'(pix_x_o) != e.x) begin bad = 1; $display("FAIL R2/R6 pix_x actual=%0d expected=%0d", pix_x_o, e.x); end
            if (int'(pix_y_o) != e.y) begin bad = 1; $display("FAIL R3/R7 pix_y actual=%0d expected=%0d", pix_y_o, e.y); end
            if (hsync_o != e.hs) begin bad = 1; $display("FAIL R2/R5 hsync actual=%0d expected=%0d", hsync_o, e.hs); end
            if (vsync_o != e.vs) begin bad = 1; $display("FAIL R3/R5 vsync actual=%0d expected=%0d", vsync_o, e.vs); end
            if (de_o != e.de) begin bad = 1; $display("FAIL R4 de actual=%0d expected=%0d", de_o, e.de); end
            if (line_hit_o != e.hit) begin bad = 1; $display("FAIL R8 line_hit actual=%0d expected=%0d", line_hit_o, e.hit); end
            if (status_o != e.st) begin bad = 1; $display("FAIL R9/R10 status actual=%0d expected=%0d", status_o, e.st); end
            if (frame_irq_o != e.irq) begin bad = 1; $display("FAIL R11 irq actual=%0d expected=%0d", frame_irq_o, e.irq); end
            if (bad) n_fail++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int hold_x, hold_y;
        // R1: state during reset.
        repeat (3) @(posedge clk);
        #8;
        chk("R1 hsync", hsync_o, 1);
        chk("R1 vsync", vsync_o, 1);
        chk("R1 de", de_o, 0);
        chk("R1 pix_x", pix_x_o, 0);
        chk("R1 pix_y", pix_y_o, 0);
        chk("R1 status", status_o, 0);
        chk("R1 irq", frame_irq_o, 0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;

        // Timing: line of 10 pixels, frame of 8 lines; match line 1.
        step(0, 1, 1, 3);
        step(0, 1, 2, 1);
        step(0, 1, 3, 2);
        step(0, 1, 4, 0);
        step(0, 1, 5, 2);
        step(0, 1, 6, 0);
        step(0, 1, 7, 1);
        step(0, 1, 8, 1);
        step(0, 1, int'(A_LINE_MATCH), 1);
        step(0, 1, int'(A_IRQ_CTRL), 3);   // R9: global + frame, leading edge
        run(3, 0);
        // R7: start from stopped.
        step(1, 1, int'(A_CTRL), 1);
        run(170, 1);

        // R6: hold with pix_en low.
        run(2, 0);
        #6;
        hold_x = pix_x_o;
        hold_y = pix_y_o;
        step(0);
        step(0);
        #6;
        chk("R6 hold x", pix_x_o, hold_x);
        chk("R6 hold y", pix_y_o, hold_y);

        // R10: clear the line flag only, then the frame flag.
        step(0, 1, int'(A_STATUS), 2);
        step(0);
        #6;
        chk("R10 only line cleared", status_o, 1);
        chk("R11 irq kept", frame_irq_o, 1);
        step(0, 1, int'(A_STATUS), 1);
        step(0);
        #6;
        chk("R10 frame cleared", status_o, 0);

        // R6: irregular pixel enable.
        for (int i = 0; i < 150; i++) step((i % 3) != 1);

        // R9: trailing-edge selection.
        step(0, 1, int'(A_IRQ_CTRL), 7);
        step(0, 1, int'(A_STATUS), 3);
        run(100, 1);

        // R9: frame enable without global enable never sets the flag.
        step(0, 1, int'(A_IRQ_CTRL), 2);
        step(0, 1, int'(A_STATUS), 3);
        run(100, 1);
        #6;
        chk("R9 no global enable", status_o[0], 0);

        // R5: both syncs active-high while running.
        step(1, 1, int'(A_CTRL), 7);
        run(90, 1);
        step(1, 1, int'(A_CTRL), 1);
        run(20, 1);

        // R7: stop is deferred to the vsync leading edge.
        step(1, 1, int'(A_CTRL), 0);
        run(100, 1);
        #6;
        chk("R7 stopped x", pix_x_o, 0);
        chk("R7 stopped y", pix_y_o, 0);
        chk("R7 stopped de", de_o, 0);
        step(1, 1, int'(A_CTRL), 1);
        run(30, 1);

        @(negedge clk);
        #1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule